// File: doc/BRIEF.md
# Configurable Parallel Handshake Port

This block is the host side of a 16-bit parallel port. It drives an output data word onto dedicated pins and reads an input data word from another set of pins. One control output and a flag input pace each transfer, and a status input is reported back to the host. Static configuration inputs set several things: the active level of every handshake signal, whether each data direction is inverted, full (interlocked) or pulse handshaking, and the event that captures each input byte. They also decide whether a reset clears the output word, and whether an 8-bit peripheral is served by packing two byte handshakes into one host transfer.

The host starts a transfer with a one-cycle write strobe and may not start another while `busy_o` is high. It reads the input word with a one-cycle read strobe. Each input byte is either sampled live at the read strobe, or captured from the pins on a chosen edge of the flag. In the edge modes a sticky data-ready bit tells the host that new data is waiting. The flag and status inputs cross into the clock domain through a two-stage synchronizer. Flag edges are found by comparing two successive synchronized samples.

Top module: `par_hsk_port`

## Requirements
- R1: With `cfg_dout_inv_i`=1 every output pin is the inverse of the logical output bit. With `cfg_din_inv_i`=1 every input pin is inverted before it is used. With 0, pins carry the logical value.
- R2: `ctl_o` equals `cfg_ctl_act_low_i` (inactive) whenever no transfer is in progress. When the control is asserted it takes the opposite level.
- R3: In full mode (`cfg_pulse_mode_i`=0), a write leaves the control inactive until the flag shows ready. The control then asserts and stays asserted while the flag is busy. It deasserts, and `busy_o` falls, once the flag has gone busy and then returned to ready.
- R4: In pulse mode (`cfg_pulse_mode_i`=1), each handshake asserts the control for exactly PULSE_W clock cycles (default 4), whatever the flag does.
- R5: Each input byte has its own latch select (`cfg_lat_lo_i`, `cfg_lat_hi_i`): 0 or 3 = sampled live at the read strobe, 1 = captured on the flag's ready-to-busy edge, 2 = captured on its busy-to-ready edge. An edge of the other kind leaves the byte unchanged.
- R6: The flag counts as ready when it is high if `cfg_flag_rdy_low_i`=0, and when it is low if `cfg_flag_rdy_low_i`=1.
- R7: `data_rdy_o` is set by an edge capture and cleared by a read strobe. If a capture and a read fall in the same cycle, the read returns the previously captured byte and `data_rdy_o` stays set.
- R8: A reset with `cfg_clr_on_rst_i`=1 sets the logical output word to 0. A reset with it at 0 leaves the output word unchanged.
- R9: In packing mode (`cfg_pack8_i`=1) a write runs two handshakes. Pins [7:0] carry the low byte during the first handshake and the high byte during the second, and pins [15:8] carry logical 0.
- R10: In packing mode the low-byte latch edge captures pins [7:0] twice. The first capture fills read bits [7:0] and the second fills bits [15:8]. `data_rdy_o` is set only after the second capture.
- R11: A write strobe while `busy_o` is high is ignored: the output word is not changed.
- R12: `sts_ok_o` is 1 when the synchronized status input is high with `cfg_sts_ok_low_i`=0, or low with `cfg_sts_ok_low_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (output word cleared synchronously) |
| wr_en_i | input | 1 | Host write strobe, starts a transfer |
| wr_data_i | input | 16 | Host output word |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 16 | Input word, valid while rd_en_i is high |
| busy_o | output | 1 | Transfer in progress |
| data_rdy_o | output | 1 | Sticky new-input-data bit |
| sts_ok_o | output | 1 | Status input in its OK state |
| pdata_o | output | 16 | Output data pins |
| pdata_i | input | 16 | Input data pins |
| ctl_o | output | 1 | Control handshake output |
| flag_i | input | 1 | Flag handshake input |
| sts_i | input | 1 | Status input |
| cfg_ctl_act_low_i | input | 1 | Control is asserted low |
| cfg_flag_rdy_low_i | input | 1 | Flag low means ready |
| cfg_sts_ok_low_i | input | 1 | Status low means OK |
| cfg_din_inv_i | input | 1 | Invert input data |
| cfg_dout_inv_i | input | 1 | Invert output data |
| cfg_pulse_mode_i | input | 1 | 1 = pulse handshake, 0 = full |
| cfg_lat_lo_i | input | 2 | Low byte latch select |
| cfg_lat_hi_i | input | 2 | High byte latch select |
| cfg_clr_on_rst_i | input | 1 | Clear output word on reset |
| cfg_pack8_i | input | 1 | Pack two byte handshakes per transfer |

## Verification
A flag edge capture and a host read strobe can land in the same clock cycle. When that happens, the capture that sets the sticky ready bit races the read that clears it. The bench provokes the collision by changing the flag and then raising the read strobe exactly two edges later. At that point the synchronized edge is present at the capture edge. The bench judges the outcome by two results: the read must return the byte captured earlier, and `data_rdy_o` must remain set so that a second read returns the new byte.

// File: rtl/par_hsk_pkg.sv
package par_hsk_pkg;
  typedef enum logic [1:0] {
    LAT_HOST_RD  = 2'd0,
    LAT_RDY2BSY  = 2'd1,
    LAT_BSY2RDY  = 2'd2,
    LAT_HOST_RD2 = 2'd3
  } lat_src_e;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_WAIT_RDY,
    HS_ASSERT,
    HS_WAIT_DONE,
    HS_PULSE
  } hs_state_e;
endpackage

// File: rtl/par_hsk_sync.sv
module par_hsk_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/par_hsk_ctrl.sv
module par_hsk_ctrl
  import par_hsk_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pulse_mode_i,
  input  logic pack_i,
  input  logic flag_rdy_i,
  output logic ctl_act_o,
  output logic busy_o,
  output logic half_o
);
  localparam int CW = $clog2(PULSE_W + 1);

  hs_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           half_q, half_d;
  logic           done;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    done    = 1'b0;
    unique case (state_q)
      HS_IDLE: if (start_i) state_d = HS_WAIT_RDY;
      HS_WAIT_RDY: begin
        if (pulse_mode_i) begin
          state_d = HS_PULSE;
          cnt_d   = '0;
        end else if (flag_rdy_i) begin
          state_d = HS_ASSERT;
        end
      end
      HS_ASSERT:    if (!flag_rdy_i) state_d = HS_WAIT_DONE;
      HS_WAIT_DONE: if (flag_rdy_i) done = 1'b1;
      HS_PULSE: begin
        if (cnt_q == CW'(PULSE_W - 1)) done = 1'b1;
        else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = HS_IDLE;
    endcase
    if (done) begin
      if (pack_i && !half_q) begin
        half_d  = 1'b1;
        state_d = HS_WAIT_RDY;
      end else begin
        half_d  = 1'b0;
        state_d = HS_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
    end
  end

  assign ctl_act_o = (state_q == HS_ASSERT) || (state_q == HS_WAIT_DONE) ||
                     (state_q == HS_PULSE);
  assign busy_o    = (state_q != HS_IDLE);
  assign half_o    = half_q;
endmodule

// File: rtl/par_hsk_inlat.sv
module par_hsk_inlat
  import par_hsk_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] din_i,
  input  logic          rdy_i,
  input  lat_src_e      lat_lo_i,
  input  lat_src_e      lat_hi_i,
  input  logic          pack_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          data_rdy_o,
  output logic          rdy_set_o
);
  localparam int HL = DW / 2;

  logic          prev_rdy_q;
  logic          r2b, b2r;
  logic          in_half_q;
  logic          rdy_q;
  logic [1:0]    evt, host_rd, ld;
  logic [HL-1:0] src  [2];
  logic [HL-1:0] lane_q [2];
  lat_src_e      sel  [2];

  assign r2b    = prev_rdy_q & ~rdy_i;
  assign b2r    = ~prev_rdy_q & rdy_i;
  assign sel[0] = lat_lo_i;
  assign sel[1] = lat_hi_i;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign evt[l]     = ((sel[l] == LAT_RDY2BSY) && r2b) ||
                        ((sel[l] == LAT_BSY2RDY) && b2r);
    assign host_rd[l] = (sel[l] == LAT_HOST_RD) || (sel[l] == LAT_HOST_RD2);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q[l] <= '0;
      else if (ld[l]) lane_q[l] <= src[l];
    end
  end

  // packing reuses the low-lane edge for both halves
  assign ld[0]  = pack_i ? (evt[0] & ~in_half_q) : evt[0];
  assign ld[1]  = pack_i ? (evt[0] & in_half_q)  : evt[1];
  assign src[0] = din_i[HL-1:0];
  assign src[1] = pack_i ? din_i[HL-1:0] : din_i[DW-1:HL];

  assign rdy_set_o = pack_i ? (evt[0] & in_half_q) : (evt[0] | evt[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_rdy_q <= 1'b0;
      in_half_q  <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      prev_rdy_q <= rdy_i;
      if (pack_i && evt[0]) in_half_q <= ~in_half_q;
      if (rdy_set_o)        rdy_q     <= 1'b1;
      else if (rd_i)        rdy_q     <= 1'b0;
    end
  end

  assign rd_data_o[HL-1:0]  = host_rd[0] ? din_i[HL-1:0] : lane_q[0];
  assign rd_data_o[DW-1:HL] = (!pack_i && host_rd[1]) ? din_i[DW-1:HL] : lane_q[1];
  assign data_rdy_o         = rdy_q;
endmodule

// File: rtl/par_hsk_port.sv
module par_hsk_port
  import par_hsk_pkg::*;
#(
  parameter int DW       = 16,
  parameter int PULSE_W  = 4,
  parameter int SYNC_STG = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        rd_en_i,
  output logic [15:0] rd_data_o,
  output logic        busy_o,
  output logic        data_rdy_o,
  output logic        sts_ok_o,
  output logic [15:0] pdata_o,
  input  logic [15:0] pdata_i,
  output logic        ctl_o,
  input  logic        flag_i,
  input  logic        sts_i,
  input  logic        cfg_ctl_act_low_i,
  input  logic        cfg_flag_rdy_low_i,
  input  logic        cfg_sts_ok_low_i,
  input  logic        cfg_din_inv_i,
  input  logic        cfg_dout_inv_i,
  input  logic        cfg_pulse_mode_i,
  input  logic [1:0]  cfg_lat_lo_i,
  input  logic [1:0]  cfg_lat_hi_i,
  input  logic        cfg_clr_on_rst_i,
  input  logic        cfg_pack8_i
);
  localparam int HL = DW / 2;

  logic [1:0]    hs_sync;
  logic          flag_s, sts_s, flag_rdy;
  logic          ctl_act, start, half;
  logic [DW-1:0] dout_q, out_word, din_log;

  par_hsk_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sts_i, flag_i}),
    .q_o   (hs_sync)
  );
  assign flag_s   = hs_sync[0];
  assign sts_s    = hs_sync[1];
  assign flag_rdy = flag_s ^ cfg_flag_rdy_low_i;
  assign sts_ok_o = sts_s ^ cfg_sts_ok_low_i;

  assign start = wr_en_i & ~busy_o;

  par_hsk_ctrl #(.PULSE_W(PULSE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .pulse_mode_i(cfg_pulse_mode_i),
    .pack_i      (cfg_pack8_i),
    .flag_rdy_i  (flag_rdy),
    .ctl_act_o   (ctl_act),
    .busy_o      (busy_o),
    .half_o      (half)
  );

  // word survives reset unless clear-on-reset is selected
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      if (cfg_clr_on_rst_i) dout_q <= '0;
    end else if (start) begin
      dout_q <= wr_data_i;
    end
  end

  assign out_word = cfg_pack8_i ?
                    {{HL{1'b0}}, (half ? dout_q[DW-1:HL] : dout_q[HL-1:0])} :
                    dout_q;
  assign pdata_o  = out_word ^ {DW{cfg_dout_inv_i}};
  assign ctl_o    = ctl_act ^ cfg_ctl_act_low_i;
  assign din_log  = pdata_i ^ {DW{cfg_din_inv_i}};

  par_hsk_inlat #(.DW(DW)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .din_i     (din_log),
    .rdy_i     (flag_rdy),
    .lat_lo_i  (lat_src_e'(cfg_lat_lo_i)),
    .lat_hi_i  (lat_src_e'(cfg_lat_hi_i)),
    .pack_i    (cfg_pack8_i),
    .rd_i      (rd_en_i),
    .rd_data_o (rd_data_o),
    .data_rdy_o(data_rdy_o),
    .rdy_set_o ()
  );
endmodule

// File: rtl/par_hsk_port_chk.sv
module par_hsk_port_chk #(
  parameter int DW      = 16,
  parameter int PULSE_W = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic          ctl_i,
  input logic          ctl_act_low_i,
  input logic          pulse_mode_i,
  input logic          rd_en_i,
  input logic          data_rdy_i,
  input logic          rdy_set_i,
  input logic          flag_rdy_i,
  input logic [DW-1:0] dout_i
);
  localparam int RW = $clog2(PULSE_W + 2);

  logic          ctl_act;
  logic [RW-1:0] run_q;

  assign ctl_act = ctl_i ^ ctl_act_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         run_q <= '0;
    else if (!ctl_act)                   run_q <= '0;
    else if (run_q != RW'(PULSE_W + 1))  run_q <= run_q + 1'b1;
  end

  AST_IDLE_CTL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (ctl_i == ctl_act_low_i));  // R2

  AST_FULL_WAITS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_mode_i && $rose(ctl_act)) |-> $past(flag_rdy_i));  // R3

  AST_PULSE_WIDTH_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_mode_i |-> (run_q <= RW'(PULSE_W)));  // R4

  AST_READ_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rdy_set_i) |=> !data_rdy_i);  // R7

  AST_CAPTURE_SETS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_set_i |=> data_rdy_i);  // R7

  AST_BUSY_WORD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(dout_i));  // R11
endmodule

bind par_hsk_port par_hsk_port_chk #(.DW(DW), .PULSE_W(PULSE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_o),
  .ctl_i        (ctl_o),
  .ctl_act_low_i(cfg_ctl_act_low_i),
  .pulse_mode_i (cfg_pulse_mode_i),
  .rd_en_i      (rd_en_i),
  .data_rdy_i   (data_rdy_o),
  .rdy_set_i    (u_lat.rdy_set_o),
  .flag_rdy_i   (flag_rdy),
  .dout_i       (dout_q)
);

// File: tb/par_hsk_port_tb.sv
module par_hsk_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW         = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0, pdata_in = '0;
  logic [15:0] rd_data, pdata_out;
  logic        busy, data_rdy, sts_ok, ctl, flag = 1'b1, sts = 1'b0;
  logic        c_ctl_low = 1'b0, c_flag_low = 1'b0, c_sts_low = 1'b0;
  logic        c_din_inv = 1'b0, c_dout_inv = 1'b0, c_pulse = 1'b1;
  logic [1:0]  c_lat_lo = 2'd0, c_lat_hi = 2'd0;
  logic        c_clr = 1'b1, c_pack = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  par_hsk_port #(.PULSE_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .busy_o(busy), .data_rdy_o(data_rdy),
    .sts_ok_o(sts_ok), .pdata_o(pdata_out), .pdata_i(pdata_in), .ctl_o(ctl),
    .flag_i(flag), .sts_i(sts), .cfg_ctl_act_low_i(c_ctl_low),
    .cfg_flag_rdy_low_i(c_flag_low), .cfg_sts_ok_low_i(c_sts_low),
    .cfg_din_inv_i(c_din_inv), .cfg_dout_inv_i(c_dout_inv),
    .cfg_pulse_mode_i(c_pulse), .cfg_lat_lo_i(c_lat_lo), .cfg_lat_hi_i(c_lat_hi),
    .cfg_clr_on_rst_i(c_clr), .cfg_pack8_i(c_pack)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(4);
  endtask

  task automatic host_write(input logic [15:0] w);
    wr_en = 1'b1; wr_data = w;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic host_read(output logic [15:0] v);
    rd_en = 1'b1;
    #1 v = rd_data;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) tick();
  endtask

  task automatic t_reset_state();
    chk(pdata_out == 16'h0000, "R8 reset clears word", pdata_out, 16'h0000);
    chk(ctl == c_ctl_low, "R2 idle control after reset", ctl, c_ctl_low);
    chk(!busy && !data_rdy, "R7 reset status", {busy, data_rdy}, 16'h0);
  endtask

  task automatic t_polarity();
    logic [15:0] v;
    c_dout_inv = 1'b1;
    host_write(16'h1234); wait_idle();
    chk(pdata_out == 16'hEDCB, "R1 inverted output", pdata_out, 16'hEDCB);
    c_dout_inv = 1'b0; tick();
    chk(pdata_out == 16'h1234, "R1 true output", pdata_out, 16'h1234);
    c_din_inv = 1'b1; pdata_in = 16'h0F0F; tick();
    host_read(v);
    chk(v == 16'hF0F0, "R1 inverted input live read", v, 16'hF0F0);
    c_din_inv = 1'b0; pdata_in = 16'hBEEF; tick();
    host_read(v);
    chk(v == 16'hBEEF, "R5 host-read lanes sample pins", v, 16'hBEEF);
  endtask

  task automatic t_pulse();
    int act_cnt = 0;
    c_ctl_low = 1'b1; tick();
    chk(ctl == 1'b1, "R2 idle level active-low control", ctl, 1'b1);
    host_write(16'h0001);
    for (int i = 0; i < 20; i++) begin
      if (ctl == 1'b0) act_cnt++;
      tick();
    end
    chk(act_cnt == PW, "R4 pulse width", 16'(act_cnt), 16'(PW));
    chk(ctl == 1'b1 && !busy, "R2 control released", ctl, 1'b1);
    c_ctl_low = 1'b0; tick();
  endtask

  task automatic t_full(input logic rdy_low);
    logic rdy_lvl, bsy_lvl;
    bit   seen;
    rdy_lvl = ~rdy_low; bsy_lvl = rdy_low;
    c_flag_low = rdy_low; c_pulse = 1'b0;
    flag = bsy_lvl; tick(4);
    host_write(16'h00AA); tick(6);
    chk(ctl == 1'b0 && busy, "R3 control held off while flag busy", ctl, 1'b0);
    flag = rdy_lvl;
    seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin tick(); seen = (ctl == 1'b1); end
    chk(seen, "R6 ready level starts handshake", ctl, 1'b1);
    flag = bsy_lvl; tick(6);
    chk(ctl == 1'b1, "R3 control held while flag busy", ctl, 1'b1);
    flag = rdy_lvl; tick(8);
    chk(ctl == 1'b0 && !busy, "R3 release after busy then ready", {ctl, busy}, 16'h0);
    flag = 1'b1; c_flag_low = 1'b0; c_pulse = 1'b1; tick(4);
  endtask

  task automatic t_status();
    sts = 1'b0; c_sts_low = 1'b1; tick(3);
    chk(sts_ok == 1'b1, "R12 low status ok", sts_ok, 1'b1);
    c_sts_low = 1'b0; tick();
    chk(sts_ok == 1'b0, "R12 low status not ok", sts_ok, 1'b0);
    sts = 1'b1; tick(3);
    chk(sts_ok == 1'b1, "R12 high status ok", sts_ok, 1'b1);
  endtask

  task automatic t_edge_latch();
    logic [15:0] v;
    c_lat_lo = 2'd1; c_lat_hi = 2'd2; tick();
    pdata_in = 16'hAA55; flag = 1'b0; tick(5);
    chk(data_rdy == 1'b1, "R7 capture sets ready", data_rdy, 1'b1);
    pdata_in = 16'h1234; flag = 1'b1; tick(5);
    host_read(v);
    chk(v == 16'h1255, "R5 per-lane edge capture", v, 16'h1255);
    chk(data_rdy == 1'b0, "R7 read clears ready", data_rdy, 1'b0);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    c_lat_lo = 2'd2; c_lat_hi = 2'd0;
    flag = 1'b0; tick(5);
    chk(data_rdy == 1'b0, "R5 other edge ignored", data_rdy, 1'b0);
    pdata_in = 16'h00C3; flag = 1'b1;
    tick(2);
    rd_en = 1'b1;
    #1 v = rd_data;
    tick();
    rd_en = 1'b0;
    chk(v[7:0] == 8'h55, "R7 colliding read returns old byte", {8'h0, v[7:0]}, 16'h0055);
    chk(data_rdy == 1'b1, "R7 capture wins over read", data_rdy, 1'b1);
    host_read(v);
    chk(v[7:0] == 8'hC3, "R7 new byte after collision", {8'h0, v[7:0]}, 16'h00C3);
    chk(data_rdy == 1'b0, "R7 cleared by following read", data_rdy, 1'b0);
  endtask

  task automatic t_busy_ignore();
    host_write(16'h2222);
    host_write(16'h3333);
    wait_idle();
    chk(pdata_out == 16'h2222, "R11 write while busy ignored", pdata_out, 16'h2222);
  endtask

  task automatic t_pack_out();
    bit seen;
    c_pack = 1'b1; tick();
    host_write(16'hA55A);
    seen = 0;
    for (int i = 0; i < 6 && !seen; i++) begin seen = (ctl == 1'b1); if (!seen) tick(); end
    chk(pdata_out == 16'h005A, "R9 low byte first", pdata_out, 16'h005A);
    for (int i = 0; i < 10 && ctl; i++) tick();
    seen = 0;
    for (int i = 0; i < 6 && !seen; i++) begin seen = (ctl == 1'b1); if (!seen) tick(); end
    chk(seen && pdata_out == 16'h00A5, "R9 high byte second", pdata_out, 16'h00A5);
    wait_idle();
    c_pack = 1'b0; tick();
  endtask

  task automatic t_pack_in();
    logic [15:0] v;
    c_pack = 1'b1; c_lat_lo = 2'd2;
    flag = 1'b0; tick(5);
    pdata_in = 16'h0011; flag = 1'b1; tick(5);
    chk(data_rdy == 1'b0, "R10 no ready after first byte", data_rdy, 1'b0);
    flag = 1'b0; tick(5);
    pdata_in = 16'h0022; flag = 1'b1; tick(5);
    chk(data_rdy == 1'b1, "R10 ready after second byte", data_rdy, 1'b1);
    host_read(v);
    chk(v == 16'h2211, "R10 packed input word", v, 16'h2211);
    c_pack = 1'b0; c_lat_lo = 2'd0; tick();
  endtask

  task automatic t_reset_hold();
    c_clr = 1'b0;
    host_write(16'h5A5A); wait_idle();
    do_reset();
    chk(pdata_out == 16'h5A5A, "R8 word kept over reset", pdata_out, 16'h5A5A);
    c_clr = 1'b1;
    do_reset();
    chk(pdata_out == 16'h0000, "R8 word cleared by reset", pdata_out, 16'h0000);
  endtask

  initial begin
    tick(2);
    do_reset();
    t_reset_state();
    t_polarity();
    t_pulse();
    t_full(1'b0);
    t_full(1'b1);
    t_status();
    t_edge_latch();
    t_collision();
    t_busy_ignore();
    t_pack_out();
    t_pack_in();
    t_reset_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 16'h1, 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule